// File: doc/BRIEF.md
# Green-Mode Off-Time Modulator

This block turns a digitised feedback level into the minimum off-time that a quasi-resonant switching sequencer must wait after each gate turn-off. At heavy load the feedback level is high and the wait is short. As the load lightens and the feedback falls, the wait stretches linearly, which lowers the switching frequency. When the feedback drops below a low threshold, the block declares a green-off condition. The wait then becomes a long start-timer period that paces sparse restart pulses. A hysteresis band stops the flag from chattering near that threshold.

The feedback arrives as an unsigned code with a one-cycle valid strobe. Parameters set the three code thresholds and the three cycle counts, so the block does not depend on the converter's resolution or on the clock rate. Each strobe produces a registered result one clock later. The result is held until the next strobe.

Top module: `gom_offtime_mod`

## Requirements
- R1: A strobed code at or above CODE_FULL makes `toff_cycles` equal CYC_SHORT and clears `green_off` on the next clock edge.
- R2: With `green_off` clear, a strobed code c with CODE_EDGE <= c < CODE_FULL gives `toff_cycles` = CYC_LONG - floor(((c - CODE_EDGE) * (CYC_LONG - CYC_SHORT) + (CODE_FULL - CODE_EDGE)/2) / (CODE_FULL - CODE_EDGE)). The segment meets CYC_LONG at CODE_EDGE and CYC_SHORT at CODE_FULL exactly.
- R3: Whenever `green_off` is set, `toff_cycles` equals CYC_START.
- R4: A strobed code below CODE_EDGE sets `green_off` on the next clock edge.
- R5: A strobed code at or above CODE_EDGE + CODE_HYST clears `green_off`. A strobed code in [CODE_EDGE, CODE_EDGE + CODE_HYST) leaves the flag unchanged.
- R6: Both outputs change only on the clock edge that samples `fb_valid` high, with one cycle of latency. Codes presented without the strobe have no effect.
- R7: Synchronous reset sets `toff_cycles` to CYC_LONG and clears `green_off`.
- R8: With `green_off` clear, `toff_cycles` never increases as the strobed code increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_valid | input | 1 | Strobe marking a new feedback code |
| fb_code | input | CODE_W | Unsigned feedback code |
| toff_cycles | output | CNT_W | Minimum off-time in clock cycles |
| green_off | output | 1 | Green-off region flag with hysteresis |

## Verification
The bench sweeps the code upward and downward across the full range. This exposes a flag that lacks hysteresis: such a design would drop out of green-off anywhere inside the band and toggle the timer between 2.1 ms-scale and microsecond values. It hits the two segment endpoints and the codes next to them, where an off-by-one or a truncating division would leave the ramp one cycle away from its plateau. It also holds the strobe low while changing the code, so a design that tracks the input continuously shows a moving output. A step-by-step reference model is compared on every clock, so any wrong count or stale flag is reported.

// File: rtl/gom_pkg.sv
package gom_pkg;
  // Which part of the transfer curve a feedback code falls in.
  typedef enum logic [1:0] {
    ZONE_FAST = 2'd0,
    ZONE_RAMP = 2'd1,
    ZONE_SLOW = 2'd2
  } zone_e;
endpackage

// File: rtl/gom_hyst.sv
module gom_hyst #(
  parameter int CODE_W    = 10,
  parameter int EDGE_CODE = 240,
  parameter int HYST_CODE = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fb_valid,
  input  logic [CODE_W-1:0] fb_code,
  output logic              green_q,
  output logic              green_nx
);
  localparam int EXIT_CODE = EDGE_CODE + HYST_CODE;

  logic below_edge, above_exit;

  assign below_edge = fb_code < CODE_W'(EDGE_CODE);
  assign above_exit = fb_code >= CODE_W'(EXIT_CODE);

  always_comb begin
    green_nx = green_q;
    if (fb_valid) begin
      if (below_edge)      green_nx = 1'b1;
      else if (above_exit) green_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) green_q <= 1'b0;
    else     green_q <= green_nx;
  end

  AST_GREEN_ENTER: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && fb_code < CODE_W'(EDGE_CODE)) |=> green_q); // R4
  AST_GREEN_EXIT: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && fb_code >= CODE_W'(EXIT_CODE)) |=> !green_q); // R5
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && fb_code >= CODE_W'(EDGE_CODE) && fb_code < CODE_W'(EXIT_CODE))
      |=> (green_q == $past(green_q))); // R5
endmodule

// File: rtl/gom_ramp.sv
module gom_ramp
  import gom_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 20,
  parameter int EDGE_CODE = 240,
  parameter int FULL_CODE = 420,
  parameter int CYC_SHORT = 2000,
  parameter int CYC_LONG  = 9500
) (
  input  logic [CODE_W-1:0] fb_code,
  output logic [CNT_W-1:0]  ramp_cnt
);
  localparam int SPAN   = FULL_CODE - EDGE_CODE;
  localparam int DELTA  = CYC_LONG - CYC_SHORT;
  localparam int PROD_W = CODE_W + CNT_W + 1;

  zone_e              zone;
  logic [CODE_W-1:0]  offs;
  logic [PROD_W-1:0]  prod;
  logic [CNT_W-1:0]   decr;

  always_comb begin
    if (fb_code >= CODE_W'(FULL_CODE))      zone = ZONE_FAST;
    else if (fb_code <= CODE_W'(EDGE_CODE)) zone = ZONE_SLOW;
    else                                    zone = ZONE_RAMP;
  end

  // Decrement from the long plateau, rounded half up to whole cycles.
  assign offs = fb_code - CODE_W'(EDGE_CODE);
  assign prod = PROD_W'(offs) * PROD_W'(DELTA) + PROD_W'(SPAN / 2);
  assign decr = CNT_W'(prod / PROD_W'(SPAN));

  always_comb begin
    unique case (zone)
      ZONE_FAST: ramp_cnt = CNT_W'(CYC_SHORT);
      ZONE_SLOW: ramp_cnt = CNT_W'(CYC_LONG);
      default:   ramp_cnt = CNT_W'(CYC_LONG) - decr;
    endcase
  end

  always_comb begin
    AST_RAMP_BOUNDS: assert (ramp_cnt >= CNT_W'(CYC_SHORT) && ramp_cnt <= CNT_W'(CYC_LONG)); // R2
  end
endmodule

// File: rtl/gom_offtime_mod.sv
module gom_offtime_mod #(
  parameter int CODE_W    = 10,
  parameter int CODE_EDGE = 240,
  parameter int CODE_FULL = 420,
  parameter int CODE_HYST = 20,
  parameter int CYC_SHORT = 2000,
  parameter int CYC_LONG  = 9500,
  parameter int CYC_START = 525000,
  localparam int CNT_W    = $clog2(CYC_START + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fb_valid,
  input  logic [CODE_W-1:0] fb_code,
  output logic [CNT_W-1:0]  toff_cycles,
  output logic              green_off
);
  logic             green_nx;
  logic [CNT_W-1:0] ramp_cnt;
  logic [CNT_W-1:0] toff_q;

  gom_hyst #(
    .CODE_W(CODE_W), .EDGE_CODE(CODE_EDGE), .HYST_CODE(CODE_HYST)
  ) u_hyst (
    .clk(clk), .rst(rst), .fb_valid(fb_valid), .fb_code(fb_code),
    .green_q(green_off), .green_nx(green_nx)
  );

  gom_ramp #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .EDGE_CODE(CODE_EDGE), .FULL_CODE(CODE_FULL),
    .CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG)
  ) u_ramp (
    .fb_code(fb_code), .ramp_cnt(ramp_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)           toff_q <= CNT_W'(CYC_LONG);
    else if (fb_valid) toff_q <= green_nx ? CNT_W'(CYC_START) : ramp_cnt;
  end

  assign toff_cycles = toff_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fb_valid |=> ($stable(toff_cycles) && $stable(green_off))); // R6
  AST_FAST_PLATEAU: assert property (@(posedge clk) disable iff (rst)
    (fb_valid && fb_code >= CODE_W'(CODE_FULL))
      |=> (toff_cycles == CNT_W'(CYC_SHORT) && !green_off)); // R1
  AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (rst)
    !green_off |-> (toff_cycles >= CNT_W'(CYC_SHORT) && toff_cycles <= CNT_W'(CYC_LONG))); // R2
  AST_GREEN_TIMER: assert property (@(posedge clk) disable iff (rst)
    green_off |-> (toff_cycles == CNT_W'(CYC_START))); // R3
endmodule

// File: tb/gom_offtime_mod_tb.sv
module gom_offtime_mod_tb;
  localparam int CODE_W = 10;
  localparam int EDGE = 240, FULL = 420, HYST = 20;
  localparam int SHORT = 2000, LONG = 9500, START = 525000;
  localparam int CNT_W = $clog2(START + 1);
  localparam int MAXC = (1 << CODE_W) - 1;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0, rst = 1'b1, fb_valid = 1'b0;
  logic [CODE_W-1:0] fb_code = '0;
  logic [CNT_W-1:0] toff_cycles;
  logic green_off;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int m_toff = LONG;
  bit m_green = 0;
  string m_tag = "R7";

  always #2 clk = ~clk; // 250 MHz

  gom_offtime_mod u_dut (
    .clk(clk), .rst(rst), .fb_valid(fb_valid), .fb_code(fb_code),
    .toff_cycles(toff_cycles), .green_off(green_off)
  );

  function automatic int ref_ramp(int c);
    if (c >= FULL) return SHORT;
    if (c <= EDGE) return LONG;
    return LONG - ((c - EDGE) * (LONG - SHORT) + (FULL - EDGE) / 2) / (FULL - EDGE);
  endfunction

  // Behavioural reference, updated at the same edge as the design.
  always @(posedge clk) begin
    bit ng;
    if (rst) begin
      m_green <= 0; m_toff <= LONG; m_tag <= "R7";
    end else if (fb_valid) begin
      ng = m_green;
      if (int'(fb_code) < EDGE) ng = 1;
      else if (int'(fb_code) >= EDGE + HYST) ng = 0;
      m_green <= ng;
      m_toff  <= ng ? START : ref_ramp(int'(fb_code));
      m_tag   <= ng ? "R3" : (int'(fb_code) >= FULL ? "R1" : "R2");
    end else begin
      m_tag <= "R6";
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(m_tag, int'(toff_cycles), m_toff);
      check({m_tag, " flag"}, int'(green_off), int'(m_green));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic apply(int c);
    @(negedge clk); fb_code = CODE_W'(c); fb_valid = 1'b1;
    @(negedge clk); fb_valid = 1'b0;
  endtask

  initial begin
    int prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", int'(toff_cycles), LONG);
    check("R7", int'(green_off), 0);

    apply(600);  check("R1", int'(toff_cycles), SHORT);
    apply(FULL); check("R1", int'(toff_cycles), SHORT);
    apply(FULL - 1); check("R2", int'(toff_cycles), ref_ramp(FULL - 1));
    apply(EDGE + HYST); check("R2", int'(toff_cycles), ref_ramp(EDGE + HYST));
    apply(EDGE); check("R2", int'(toff_cycles), LONG);
    apply(EDGE + 1); check("R2", int'(toff_cycles), ref_ramp(EDGE + 1));

    // Code moves without the strobe: outputs must not follow.
    fb_code = CODE_W'(0);
    repeat (5) @(negedge clk);
    check("R6", int'(toff_cycles), ref_ramp(EDGE + 1));
    check("R6", int'(green_off), 0);

    apply(EDGE - 1); check("R4", int'(green_off), 1); check("R3", int'(toff_cycles), START);
    apply(EDGE);     check("R5", int'(green_off), 1); check("R3", int'(toff_cycles), START);
    apply(EDGE + HYST - 1); check("R5", int'(green_off), 1);
    apply(EDGE + HYST); check("R5", int'(green_off), 0);
    check("R2", int'(toff_cycles), ref_ramp(EDGE + HYST));
    apply(0);    check("R4", int'(green_off), 1);
    apply(MAXC); check("R1", int'(toff_cycles), SHORT);

    // Rising sweep: monotonic off-time while the flag is clear.
    prev = LONG;
    for (int c = EDGE + HYST; c <= MAXC; c += 3) begin
      apply(c);
      check("R8", int'(toff_cycles <= CNT_W'(prev)), 1);
      prev = int'(toff_cycles);
    end
    // Falling then rising sweep through the band, back to back strobes.
    @(negedge clk);
    for (int c = MAXC; c >= 0; c -= 2) begin
      fb_code = CODE_W'(c); fb_valid = 1'b1; @(negedge clk);
    end
    for (int c = 0; c <= 500; c++) begin
      fb_code = CODE_W'(c); fb_valid = (c % 3) != 1; @(negedge clk);
    end
    fb_valid = 1'b0;
    repeat (3) @(negedge clk);

    // Reset in mid-operation.
    apply(100);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R7", int'(toff_cycles), LONG);
    check("R7", int'(green_off), 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule